// File: doc/BRIEF.md
# Heartbeat Interval Fault Monitor

This block supervises the periodic cycle-start heartbeat that a bus root sends. Nominally one heartbeat arrives every 125 microseconds. The heartbeat reaches the monitor as a single-cycle pulse. The monitor measures the number of clock cycles between consecutive pulses and compares that count with two programmable limits:

- **Missing heartbeat.** If a gap grows past the upper limit, the root is presumed to have failed.
- **Early heartbeat.** If a pulse arrives before the lower limit, a second root is presumed to be active.

A separate countdown timer gives an independent lost-heartbeat indication. Each heartbeat reloads it with a programmable value, and it reports a timeout when it reaches zero.

All three fault conditions are latched as sticky flags. Each flag has a one-cycle event pulse that marks the cycle in which the fault is first detected. Any latched fault drives a request for the fault-isolation procedure, which is handled elsewhere. The limits and the countdown value are written through a small configuration port. That port accepts writes only while the monitor is disabled.

Top module: `hb_interval_monitor`

## Requirements
- R1: After reset, all fault flags, event pulses and the isolation request are low. The limit registers hold their parameter defaults.
- R2: An interval is the number of clock cycles from one heartbeat pulse to the next. Once timing is running, if the count since the last pulse reaches the upper limit and no pulse is present in that cycle, the missing-heartbeat flag rises on the next cycle. Timing then stops until the next pulse.
- R3: A pulse whose interval equals the upper limit exactly is on time and raises no missing-heartbeat fault.
- R4: A pulse whose interval is below the lower limit raises the early-heartbeat flag on the next cycle. An interval equal to the lower limit is accepted.
- R5: The first pulse after reset, after enable rises, or after a missing-heartbeat detection only starts interval timing. It is never checked against the lower limit.
- R6: The lost-heartbeat timer works as follows:
  - It is loaded with the programmed value on every heartbeat pulse and on every disabled cycle.
  - It decrements once per enabled cycle without a pulse.
  - It sets the lost flag on the step from 1 to 0, and stays at zero until the next reload.
  - A programmed value of 0 never times out.
- R7: Fault flags stay set until `fault_clear` is high at a clock edge, and a detection in that same cycle wins. Each event output pulses for one cycle only when its flag goes from low to high.
- R8: `isolate_req` is high whenever any fault flag is set.
- R9: A configuration write uses `cfg_sel` = 0 for the lower limit, 1 for the upper limit, 2 for the timer value, and 3 for nothing. A write takes effect only while `enable` is low and is ignored while `enable` is high.
- R10: While `enable` is low, no fault is detected and interval timing is reset. Flags already set are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitor enable; while high, configuration is frozen |
| hb_pulse | input | 1 | One-cycle heartbeat marker |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lower limit, 1 upper limit, 2 timer value, 3 none |
| cfg_wdata | input | CNT_W | Configuration write data, in clock cycles |
| fault_clear | input | 1 | Clears all sticky fault flags |
| flag_missing | output | 1 | Sticky missing-heartbeat (root failure) flag |
| flag_early | output | 1 | Sticky early-heartbeat (multiple root) flag |
| flag_lost | output | 1 | Sticky lost-heartbeat timer expiry flag |
| evt_missing | output | 1 | One-cycle pulse when missing fault first set |
| evt_early | output | 1 | One-cycle pulse when early fault first set |
| evt_lost | output | 1 | One-cycle pulse when timer expiry first set |
| isolate_req | output | 1 | Fault-isolation request |

## Verification
The bench targets the limit edges: intervals exactly equal to the upper limit and to the lower limit. A comparison that is off by one at either edge would raise a false missing or early fault there. It also targets the first pulse after a missing-heartbeat detection, which a design that keeps timing would wrongly report as early. Limit writes are attempted while the monitor is enabled; if such a write got through, a later short interval would no longer be flagged. A zero timer value is checked for spurious expiry. The timer is also re-armed from a disabled cycle, where a design that reloads only on pulses would never time out.

// File: rtl/hbm_pkg.sv
// Package: shared selectors and fault indices for the heartbeat monitor.
// Assumes: cfg_sel values are fixed by the configuration port contract.
package hbm_pkg;
    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_MAX  = 2'd1,
        SEL_LOST = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    localparam int FLT_MISS  = 0;
    localparam int FLT_EARLY = 1;
    localparam int FLT_LOST  = 2;
    localparam int NUM_FLT   = 3;
endpackage

// File: rtl/hbm_cfg_regs.sv
// Module: holds the lower limit, upper limit and timer reload value.
// Assumes: writes are accepted only while the monitor is disabled.
module hbm_cfg_regs
    import hbm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MIN_RST  = 20,
    parameter int MAX_RST  = 30,
    parameter int LOST_RST = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] min_q,
    output logic [CNT_W-1:0] max_q,
    output logic [CNT_W-1:0] lost_q
);
    logic wr_ok;
    assign wr_ok = cfg_wr && !enable;

    // Gated register writes with parameter defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q  <= CNT_W'(MIN_RST);
            max_q  <= CNT_W'(MAX_RST);
            lost_q <= CNT_W'(LOST_RST);
        end else if (wr_ok) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_MIN:  min_q  <= cfg_wdata;
                SEL_MAX:  max_q  <= cfg_wdata;
                SEL_LOST: lost_q <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    // R9: configuration is frozen while enabled
    a_r9_frozen_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(min_q) && $stable(max_q) && $stable(lost_q)));
endmodule

// File: rtl/hbm_interval_check.sv
// Module: counts cycles between heartbeats and flags short or long gaps.
// Assumes: upper limit >= 1; limits do not change while enabled.
module hbm_interval_check #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hb_pulse,
    input  logic [CNT_W-1:0] min_q,
    input  logic [CNT_W-1:0] max_q,
    output logic             det_miss,
    output logic             det_early
);
    logic             run_q;
    logic [CNT_W-1:0] elapsed_q;

    // Interval counter: restarts on a pulse, stops on a missing heartbeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            elapsed_q <= '0;
        end else if (!enable) begin
            run_q     <= 1'b0;
            elapsed_q <= '0;
        end else if (hb_pulse) begin
            run_q     <= 1'b1;
            elapsed_q <= CNT_W'(1);
        end else if (run_q) begin
            if (elapsed_q == max_q) begin
                run_q     <= 1'b0;
                elapsed_q <= '0;
            end else begin
                elapsed_q <= elapsed_q + CNT_W'(1);
            end
        end
    end

    // Detection terms evaluated in the cycle a pulse arrives or the gap expires.
    always_comb begin
        det_early = enable && hb_pulse && run_q && (elapsed_q < min_q);
        det_miss  = enable && !hb_pulse && run_q && (elapsed_q == max_q);
    end

    // R2: running count never passes the upper limit
    a_r2_elapsed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && max_q != '0) |-> (elapsed_q <= max_q));
endmodule

// File: rtl/hbm_lost_timer.sv
// Module: reloadable countdown that signals expiry on reaching zero.
// Assumes: a reload value of zero keeps the timer idle.
module hbm_lost_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hb_pulse,
    input  logic [CNT_W-1:0] lost_q,
    output logic             det_lost
);
    logic [CNT_W-1:0] cnt_q;

    // Countdown: reload when disabled or on a pulse, else step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || hb_pulse) begin
            cnt_q <= lost_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expiry on the step from one to zero.
    assign det_lost = enable && !hb_pulse && (cnt_q == CNT_W'(1));

    // R6: each heartbeat reloads the timer
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hb_pulse) |=> (cnt_q == $past(lost_q)));
    // R6: timer steps down by one per idle enabled cycle
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !hb_pulse && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/hbm_fault_latch.sv
// Module: sticky fault flags with first-detection event pulses.
// Assumes: a detection in the clearing cycle keeps the flag set.
module hbm_fault_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] det,
    output logic [N-1:0] flag,
    output logic [N-1:0] evt
);
    for (genvar i = 0; i < N; i++) begin : g_flt
        // Per-fault latch and rising-edge event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
                evt[i]  <= 1'b0;
            end else begin
                flag[i] <= det[i] || (flag[i] && !clr);
                evt[i]  <= det[i] && !flag[i];
            end
        end

        // R7: flag holds until cleared
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr) |=> flag[i]);
        // R7: event only accompanies a set flag
        a_r7_evt_flag: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |-> flag[i]);
        // R7: event lasts a single cycle
        a_r7_evt_once: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> !evt[i]);
    end
endmodule

// File: rtl/hb_interval_monitor.sv
// Module: top of the heartbeat interval fault monitor.
// Assumes: hb_pulse is one cycle wide and synchronous to clk.
module hb_interval_monitor
    import hbm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MIN_RST  = 20,
    parameter int MAX_RST  = 30,
    parameter int LOST_RST = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hb_pulse,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             fault_clear,
    output logic             flag_missing,
    output logic             flag_early,
    output logic             flag_lost,
    output logic             evt_missing,
    output logic             evt_early,
    output logic             evt_lost,
    output logic             isolate_req
);
    logic [CNT_W-1:0]   min_q, max_q, lost_q;
    logic [NUM_FLT-1:0] det, flag, evt;

    hbm_cfg_regs #(
        .CNT_W(CNT_W), .MIN_RST(MIN_RST), .MAX_RST(MAX_RST), .LOST_RST(LOST_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .min_q(min_q), .max_q(max_q), .lost_q(lost_q)
    );

    hbm_interval_check #(.CNT_W(CNT_W)) u_ivl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hb_pulse(hb_pulse),
        .min_q(min_q), .max_q(max_q),
        .det_miss(det[FLT_MISS]), .det_early(det[FLT_EARLY])
    );

    hbm_lost_timer #(.CNT_W(CNT_W)) u_lost (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hb_pulse(hb_pulse),
        .lost_q(lost_q), .det_lost(det[FLT_LOST])
    );

    hbm_fault_latch #(.N(NUM_FLT)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr(fault_clear),
        .det(det), .flag(flag), .evt(evt)
    );

    // Output mapping and isolation request.
    always_comb begin
        flag_missing = flag[FLT_MISS];
        flag_early   = flag[FLT_EARLY];
        flag_lost    = flag[FLT_LOST];
        evt_missing  = evt[FLT_MISS];
        evt_early    = evt[FLT_EARLY];
        evt_lost     = evt[FLT_LOST];
        isolate_req  = |flag;
    end

    // R8: a new isolation request always comes with a first-detection event
    a_r8_req_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isolate_req) |-> (|evt));
endmodule

// File: tb/hb_interval_monitor_test.sv
module hb_interval_monitor_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n, enable, hb_pulse, cfg_wr, fault_clear;
    logic [1:0] cfg_sel;
    logic [W-1:0] cfg_wdata;
    logic flag_missing, flag_early, flag_lost;
    logic evt_missing, evt_early, evt_lost, isolate_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hb_interval_monitor #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hb_pulse(hb_pulse),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .fault_clear(fault_clear),
        .flag_missing(flag_missing), .flag_early(flag_early), .flag_lost(flag_lost),
        .evt_missing(evt_missing), .evt_early(evt_early), .evt_lost(evt_lost),
        .isolate_req(isolate_req)
    );

    // Behavioural reference model
    int m_min, m_max, m_lost, m_el, m_cnt;
    bit m_run;
    bit m_flag [3];
    bit m_evt  [3];

    always @(posedge clk) begin
        bit d [3];
        d[0] = 0; d[1] = 0; d[2] = 0;
        if (!rst_n) begin
            m_min = 20; m_max = 30; m_lost = 40;
            m_run = 0; m_el = 0; m_cnt = 0;
            for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_evt[i] = 0; end
        end else begin
            if (!enable) begin
                m_run = 0; m_el = 0; m_cnt = m_lost;
            end else begin
                if (hb_pulse) begin
                    if (m_run && m_el < m_min) d[1] = 1;
                    m_run = 1; m_el = 1;
                    m_cnt = m_lost;
                end else begin
                    if (m_run) begin
                        if (m_el == m_max) begin d[0] = 1; m_run = 0; m_el = 0; end
                        else m_el = m_el + 1;
                    end
                    if (m_cnt > 0) begin
                        if (m_cnt == 1) d[2] = 1;
                        m_cnt = m_cnt - 1;
                    end
                end
            end
            if (cfg_wr && !enable) begin
                case (cfg_sel)
                    2'd0: m_min = int'(cfg_wdata);
                    2'd1: m_max = int'(cfg_wdata);
                    2'd2: m_lost = int'(cfg_wdata);
                    default: ;
                endcase
            end
            for (int i = 0; i < 3; i++) begin
                m_evt[i]  = d[i] && !m_flag[i];
                m_flag[i] = d[i] || (m_flag[i] && !fault_clear);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 flag_missing", flag_missing, m_flag[0]);
            chk("R4 flag_early",   flag_early,   m_flag[1]);
            chk("R6 flag_lost",    flag_lost,    m_flag[2]);
            chk("R7 evt_missing",  evt_missing,  m_evt[0]);
            chk("R7 evt_early",    evt_early,    m_evt[1]);
            chk("R7 evt_lost",     evt_lost,     m_evt[2]);
            chk("R8 isolate_req",  isolate_req,  m_flag[0] | m_flag[1] | m_flag[2]);
        end
    end

    task automatic idle(input int n);
        hb_pulse = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic beat();
        hb_pulse = 1;
        @(negedge clk);
        hb_pulse = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input int val);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = W'(val);
        @(negedge clk);
        cfg_wr = 0; cfg_sel = 2'd3;
    endtask

    task automatic clear();
        fault_clear = 1;
        @(negedge clk);
        fault_clear = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        rst_n = 0; enable = 0; hb_pulse = 0; cfg_wr = 0; cfg_sel = 2'd3;
        cfg_wdata = '0; fault_clear = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset flags", flag_missing | flag_early | flag_lost, 1'b0);
        chk("R1 reset isolate", isolate_req, 1'b0);

        // R9: program limits while disabled
        wr(2'd0, 10); wr(2'd1, 20); wr(2'd2, 25);
        enable = 1;
        // steady beats at spacing 15
        for (int k = 0; k < 5; k++) begin beat(); idle(14); end
        chk("R6 no expiry with steady beats", flag_lost, 1'b0);
        // R3: exactly the upper limit
        beat(); idle(19); beat();
        chk("R3 interval at max is on time", flag_missing, 1'b0);
        // R4: exactly the lower limit accepted
        idle(9); beat();
        chk("R4 interval at min accepted", flag_early, 1'b0);
        // R4: one short
        idle(8); beat();
        @(negedge clk);
        chk("R4 short interval flagged", flag_early, 1'b1);
        idle(3);
        chk("R7 flag sticky", flag_early, 1'b1);
        clear();
        chk("R7 flag cleared", flag_early, 1'b0);

        // R2 and R6: long gap
        beat(); idle(30);
        chk("R2 missing heartbeat flagged", flag_missing, 1'b1);
        chk("R6 timer expired", flag_lost, 1'b1);
        clear();
        // R5: first pulse after missing detection is not checked
        beat(); @(negedge clk);
        chk("R5 first pulse not early", flag_early, 1'b0);
        idle(1); beat(); @(negedge clk);
        chk("R4 second short pulse early", flag_early, 1'b1);
        clear();

        // R9: write while enabled is ignored
        wr(2'd0, 1);
        beat(); idle(4); beat(); @(negedge clk);
        chk("R9 ignored write kept min", flag_early, 1'b1);
        clear();

        // R10: disabled, no detection
        enable = 0;
        idle(60);
        chk("R10 no missing while disabled", flag_missing, 1'b0);
        chk("R10 no expiry while disabled", flag_lost, 1'b0);
        // R6: re-enabled timer arms from the disabled reload
        enable = 1;
        idle(30);
        chk("R6 expiry after enable", flag_lost, 1'b1);
        chk("R5 no interval timing before first pulse", flag_missing, 1'b0);

        // R6: zero value never expires
        enable = 0;
        wr(2'd2, 0);
        clear();
        enable = 1;
        idle(80);
        chk("R6 zero value idle", flag_lost, 1'b0);
        chk("R8 no request without fault", isolate_req, 1'b0);

        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            summary();
        end
    end
endmodule